// File: doc/BRIEF.md
# Duplex Binary Squarer

This block squares an unsigned operand in pure combinational logic. For every output column it forms the duplex of the operand bits whose indices add up to that column. The duplex is twice the sum of the bit products taken as symmetric pairs from the outside in. When the column index is even it also includes the middle bit, because a bit squared is the bit itself. The column values then pass along a carry chain from the least significant column upward, and each column leaves one result bit behind.

A general multiplier forms every bit product. This block forms each cross product once and doubles it with a one-bit shift, so it needs roughly half the AND terms. It is meant to sit in a datapath that needs x squared with no pipeline delay. It has no clock and no state. The output follows the operand after the settling time of the logic.

Top module: `duplex_squarer`

## Requirements
- R1: For every operand value, `sq` equals the unsigned product `x*x` over the full width of 2*W bits, and no carry is left over past the top column.
- R2: Bit 0 of `sq` always equals bit 0 of `x`.
- R3: Bit 1 of `sq` is 0 for every operand.
- R4: An operand of all zeros gives a square of 0. An operand of all ones (W=8: 255) gives (2^W-1)^2 (W=8: 65025, hex FE01).
- R5: An operand with exactly one bit set, at index i, gives a square with exactly one bit set, at index 2*i.
- R6: For an odd operand, the three low bits of `sq` read binary 001.
- R7: The square depends on the present operand only. After any change of `x`, `sq` holds the new square within the same clock period, whatever value came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | W (8) | Unsigned operand |
| sq | output | 2*W (16) | Unsigned square of the operand |

## Verification
The bench builds the block at its default width of eight bits. At that width all 256 operand values fit in a short run, so the square is compared against a behavioural integer model for every value, not a sample. Walking single-bit operands, the all-ones operand and sequences of operands in reversed and alternating order run alongside the exhaustive sweep. These cover the columns with the deepest carry and show that no earlier operand leaves a trace in the result.

// File: rtl/sqr_pkg.sv
package sqr_pkg;

    // Width of one column's duplex value: at most W/2 doubled pairs plus a middle bit.
    function automatic int dup_width(input int w);
        return $clog2(w + 2);
    endfunction

    // Width of the carry passed between columns: bounded by W+1.
    function automatic int carry_width(input int w);
        return $clog2(2 * w + 3);
    endfunction

    function automatic int col_count(input int w);
        return 2 * w - 1;
    endfunction

endpackage

// File: rtl/sqr_duplex_col.sv
module sqr_duplex_col #(
    parameter int W  = 8,
    parameter int K  = 0,
    parameter int DW = 4
) (
    input  logic [W-1:0]  x,
    output logic [DW-1:0] dup
);
    // Lowest index i whose partner K-i is still inside the operand.
    localparam int  LO      = (K >= W) ? (K - W + 1) : 0;
    localparam bit  HAS_MID = ((K % 2) == 0);
    localparam int  MID     = K / 2;

    logic [DW-1:0] pair_sum;

    always_comb begin
        pair_sum = '0;
        for (int i = LO; 2 * i < K; i++) begin
            pair_sum = pair_sum + DW'(x[i] & x[K-i]);
        end
    end

    // Doubling by shift; the lone middle bit squares to itself.
    always_comb begin
        dup = (pair_sum << 1) + DW'(HAS_MID ? x[MID] : 1'b0);
    end

endmodule

// File: rtl/sqr_carry_chain.sv
module sqr_carry_chain #(
    parameter int W  = 8,
    parameter int DW = 4,
    parameter int CW = 5
) (
    input  logic [2*W-2:0][DW-1:0] dup,
    output logic [2*W-1:0]         sq,
    output logic [CW-2:0]          rest
);
    logic [2*W-1:0][CW-1:0] carry;

    assign carry[0] = '0;

    for (genvar k = 0; k < 2 * W - 1; k++) begin : g_col
        logic [CW-1:0] total;
        assign total        = CW'(dup[k]) + carry[k];
        assign sq[k]        = total[0];
        assign carry[k+1]   = total >> 1;
    end

    assign sq[2*W-1] = carry[2*W-1][0];
    assign rest      = carry[2*W-1][CW-1:1];

endmodule

// File: rtl/duplex_squarer.sv
module duplex_squarer #(
    parameter int W = 8
) (
    input  logic [W-1:0]   x,
    output logic [2*W-1:0] sq
);
    localparam int DW   = sqr_pkg::dup_width(W);
    localparam int CW   = sqr_pkg::carry_width(W);
    localparam int NCOL = sqr_pkg::col_count(W);

    logic [NCOL-1:0][DW-1:0] col_dup;
    logic [CW-2:0]           chain_rest;

    for (genvar k = 0; k < NCOL; k++) begin : g_dup
        sqr_duplex_col #(
            .W  (W),
            .K  (k),
            .DW (DW)
        ) u_col (
            .x   (x),
            .dup (col_dup[k])
        );
    end

    sqr_carry_chain #(
        .W  (W),
        .DW (DW),
        .CW (CW)
    ) u_chain (
        .dup  (col_dup),
        .sq   (sq),
        .rest (chain_rest)
    );

endmodule

// File: rtl/duplex_squarer_chk.sv
module duplex_squarer_chk #(
    parameter int W = 8
) (
    input logic [W-1:0]                         x,
    input logic [2*W-1:0]                       sq,
    input logic [sqr_pkg::carry_width(W)-2:0]   chain_rest
);
    logic [2*W-1:0] wide_x;
    assign wide_x = (2*W)'(x);

    always_comb begin
        p_square_value_r1: assert (sq == wide_x * wide_x);
        p_no_residue_r1:   assert (chain_rest == '0);
        p_low_bit_r2:      assert (sq[0] == x[0]);
        p_bit1_zero_r3:    assert (sq[1] == 1'b0);
        if (x == '0) begin
            p_zero_in_r4:  assert (sq == '0);
        end
        if ($countones(x) == 1) begin
            p_single_bit_r5: assert ($countones(sq) == 1);
        end
        if (x[0]) begin
            p_odd_low_r6:  assert (sq[2:0] == 3'b001);
        end
    end

endmodule

bind duplex_squarer duplex_squarer_chk #(.W(W)) u_chk (
    .x          (x),
    .sq         (sq),
    .chain_rest (chain_rest)
);

// File: tb/duplex_squarer_tb_top.sv
module duplex_squarer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int WATCHDOG   = 20000;

    logic           clk = 1'b0;
    logic [W-1:0]   x   = '0;
    logic [2*W-1:0] sq;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    duplex_squarer #(.W(W)) dut_i (
        .x  (x),
        .sq (sq)
    );

    // Apply an operand at the rising edge, compare at the falling edge.
    task automatic apply_and_check(input int val, input string req);
        longint expv;
        @(posedge clk);
        x = W'(val);
        @(negedge clk);
        expv = longint'(val) * longint'(val);
        checks++;
        if (longint'(sq) != expv) begin
            failures++;
            $display("FAIL %s x=%0d actual=%0d expected=%0d", req, val, sq, expv);
        end
    endtask

    task automatic check_bits(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s x=%0d actual=%0d expected=%0d", req, x, actual, expected);
        end
    endtask

    initial begin
        // R4: zero operand from the first cycle
        apply_and_check(0, "R4");
        check_bits("R4", int'(sq), 0);

        // R4: all-ones operand
        apply_and_check((1 << W) - 1, "R4");
        check_bits("R4", int'(sq), 65025);

        // R1: exhaustive sweep, ascending
        for (int v = 0; v < (1 << W); v++) begin
            apply_and_check(v, "R1");
            // R2: low bit follows operand
            check_bits("R2", int'(sq[0]), v % 2);
            // R3: bit 1 always clear
            check_bits("R3", int'(sq[1]), 0);
            // R6: odd operands end in 001
            if (v % 2 == 1) check_bits("R6", int'(sq[2:0]), 1);
        end

        // R5: walking single bit
        for (int i = 0; i < W; i++) begin
            apply_and_check(1 << i, "R5");
            check_bits("R5", $countones(sq), 1);
            check_bits("R5", int'(sq[2*i]), 1);
        end

        // R7: descending and alternating sequences, no memory of prior operand
        for (int v = (1 << W) - 1; v >= 0; v -= 7) begin
            apply_and_check(v, "R7");
        end
        for (int i = 0; i < 32; i++) begin
            apply_and_check((i % 2 == 0) ? 8'hAA : 8'h55, "R7");
            apply_and_check((i % 2 == 0) ? 8'hFF : 8'h01, "R7");
        end

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule